// File: doc/BRIEF.md
# Page Group Write Protection Checker

This block sits in front of the program/erase engine of an embedded flash macro. Every program, page-erase or mass-erase request is compared with an active protection mask. Each mask bit guards one group of two adjacent pages. A request that hits a guarded group is dropped and a sticky protection-error flag is raised. A request that is allowed is forwarded to the engine as a one-cycle proceed pulse, carrying its operation code and page.

The active mask is a shadow copy of the option-byte value. It is refreshed only when an option reload command arrives. An erase of the option area forces the next reload to load the all-unprotected value. Three sticky flags are kept: end of operation (reported by the engine), protection error and programming error (reported by the engine). Software clears them by writing 1. One enable gates end of operation onto the interrupt line. A second enable is shared by the two error flags.

Top module: `wpg_guard`

## Requirements
- R1: The group that guards a page is the page number shifted right by one. Mask bit g equal to 1 means group g is unprotected, and 0 means it is protected.
- R2: A program (op 2'b00) or page erase (op 2'b01) on a protected group gives no proceed pulse. It sets the protection-error flag, which is visible one cycle after the request.
- R3: An allowed request gives `go_o` high for exactly the cycle after the request. In that cycle `go_op_o` and `go_page_o` carry the request's op and page. `go_o` is low in every cycle that does not follow a request.
- R4: A mass erase (op 2'b10) is rejected with the protection-error flag if any bit of the active mask is 0. It proceeds only when all bits are 1.
- R5: A change on `opt_mask_i` has no effect until `opt_reload_i` is pulsed. A request presented in the same cycle as a reload is judged against the mask from before the reload.
- R6: A pulse on `opt_erase_i` makes the next reload load all ones, whatever `opt_mask_i` holds. Without a reload, the erase pulse has no effect.
- R7: `done_i` sets the end-of-operation flag. That flag drives `irq_o` only while `eop_ie_i` is 1.
- R8: The protection-error and programming-error flags (the latter set by `pgerr_i`) both drive `irq_o` through the single enable `err_ie_i`.
- R9: Flags are sticky. A 1 in `clr_i` clears a flag (bit 0 end of operation, bit 1 protection error, bit 2 programming error). A set in the same cycle as a clear leaves the flag set.
- R10: After reset all flags are 0, `go_o` is 0, and every group is protected until the first reload.
- R11: The reserved op 2'b11 is ignored. It gives no proceed pulse and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 00 program, 01 page erase, 10 mass erase, 11 reserved |
| req_page_i | input | PAGE_W | Target page number |
| opt_mask_i | input | GROUPS | Stored option protection value |
| opt_reload_i | input | 1 | Copy the option value into the active mask |
| opt_erase_i | input | 1 | Option area erased; next reload loads all ones |
| done_i | input | 1 | Engine completed an operation |
| pgerr_i | input | 1 | Engine programming error |
| eop_ie_i | input | 1 | End-of-operation interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| clr_i | input | 3 | Write-1-to-clear flag strobes |
| go_o | output | 1 | Proceed pulse to the engine |
| go_op_o | output | 2 | Op forwarded with the pulse |
| go_page_o | output | PAGE_W | Page forwarded with the pulse |
| eop_o | output | 1 | End-of-operation flag |
| wrp_err_o | output | 1 | Protection-error flag |
| pg_err_o | output | 1 | Programming-error flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in the same cycle. The first is a request together with a mask reload. The bench raises both in one cycle, with a new value on the option input that would flip the decision. It expects the old mask to decide, and the new mask to decide the next request. The second is a flag set together with its clear strobe. The bench sends a blocked request while writing 1 to the protection-error clear bit, and expects the flag to stay set and to drop only under a later lone clear.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'b00,
    OP_PERASE = 2'b01,
    OP_MERASE = 2'b10,
    OP_RSVD   = 2'b11
  } wp_op_e;

  localparam int NFLAGS   = 3;
  localparam int FLAG_EOP = 0;
  localparam int FLAG_WRP = 1;
  localparam int FLAG_PGE = 2;
endpackage

// File: rtl/wpg_mask_reg.sv
module wpg_mask_reg #(
  parameter int GROUPS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_i,
  input  logic              erase_i,
  input  logic [GROUPS-1:0] opt_mask_i,
  output logic [GROUPS-1:0] mask_o
);
  logic [GROUPS-1:0] mask_q;
  logic              erased_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      erased_q <= 1'b0;
    end else begin
      if (reload_i) begin
        mask_q   <= (erased_q || erase_i) ? '1 : opt_mask_i;
        erased_q <= 1'b0;
      end else if (erase_i) begin
        erased_q <= 1'b1;
      end
    end
  end

  assign mask_o = mask_q;

  // R5
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_i |=> $stable(mask_q));

  // R6
  erase_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && erase_i) |=> (&mask_q));
endmodule

// File: rtl/wpg_lookup.sv
module wpg_lookup
  import wpg_pkg::*;
#(
  parameter int GROUPS = 32,
  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic              valid_i,
  input  wp_op_e            op_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic [GROUPS-1:0] mask_i,
  output logic              allow_o,
  output logic              block_o
);
  logic grp_open;
  logic all_open;

  assign grp_open = mask_i[grp_i];
  assign all_open = &mask_i;

  always_comb begin
    allow_o = 1'b0;
    block_o = 1'b0;
    if (valid_i) begin
      unique case (op_i)
        OP_PROG, OP_PERASE: begin
          allow_o = grp_open;
          block_o = !grp_open;
        end
        OP_MERASE: begin
          allow_o = all_open;
          block_o = !all_open;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wpg_status.sv
module wpg_status
  import wpg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NFLAGS-1:0] set_i,
  input  logic [NFLAGS-1:0] clr_i,
  input  logic              eop_ie_i,
  input  logic              err_ie_i,
  output logic [NFLAGS-1:0] flags_o,
  output logic              irq_o
);
  logic [NFLAGS-1:0] flags_q;

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_q[i] <= 1'b0;
      else if (set_i[i])  flags_q[i] <= 1'b1;
      else if (clr_i[i])  flags_q[i] <= 1'b0;
    end

    // R9
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flags_q[i]);

    // R9
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[i] && !clr_i[i]) |=> flags_q[i]);
  end

  assign flags_o = flags_q;
  assign irq_o   = (flags_q[FLAG_EOP] & eop_ie_i)
                 | ((flags_q[FLAG_WRP] | flags_q[FLAG_PGE]) & err_ie_i);
endmodule

// File: rtl/wpg_guard.sv
module wpg_guard
  import wpg_pkg::*;
#(
  parameter int NUM_PAGES = 64,
  localparam int GROUPS = NUM_PAGES / 2,
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [PAGE_W-1:0] req_page_i,
  input  logic [GROUPS-1:0] opt_mask_i,
  input  logic              opt_reload_i,
  input  logic              opt_erase_i,
  input  logic              done_i,
  input  logic              pgerr_i,
  input  logic              eop_ie_i,
  input  logic              err_ie_i,
  input  logic [2:0]        clr_i,
  output logic              go_o,
  output logic [1:0]        go_op_o,
  output logic [PAGE_W-1:0] go_page_o,
  output logic              eop_o,
  output logic              wrp_err_o,
  output logic              pg_err_o,
  output logic              irq_o
);
  logic [GROUPS-1:0] active_mask;
  logic [GRP_W-1:0]  grp;
  logic              allow, block;
  logic [NFLAGS-1:0] set_vec, flags;
  wp_op_e            op;

  assign op  = wp_op_e'(req_op_i);
  assign grp = req_page_i[PAGE_W-1:1];

  wpg_mask_reg #(.GROUPS(GROUPS)) u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reload_i   (opt_reload_i),
    .erase_i    (opt_erase_i),
    .opt_mask_i (opt_mask_i),
    .mask_o     (active_mask)
  );

  wpg_lookup #(.GROUPS(GROUPS)) u_lookup (
    .valid_i (req_valid_i),
    .op_i    (op),
    .grp_i   (grp),
    .mask_i  (active_mask),
    .allow_o (allow),
    .block_o (block)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLAG_EOP] = done_i;
    set_vec[FLAG_WRP] = block;
    set_vec[FLAG_PGE] = pgerr_i;
  end

  wpg_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_i    (clr_i),
    .eop_ie_i (eop_ie_i),
    .err_ie_i (err_ie_i),
    .flags_o  (flags),
    .irq_o    (irq_o)
  );

  logic              go_q;
  logic [1:0]        op_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q   <= 1'b0;
      op_q   <= '0;
      page_q <= '0;
    end else begin
      go_q <= allow;
      if (allow) begin
        op_q   <= req_op_i;
        page_q <= req_page_i;
      end
    end
  end

  assign go_o      = go_q;
  assign go_op_o   = op_q;
  assign go_page_o = page_q;
  assign eop_o     = flags[FLAG_EOP];
  assign wrp_err_o = flags[FLAG_WRP];
  assign pg_err_o  = flags[FLAG_PGE];

  // R2
  blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block |=> (!go_o && wrp_err_o));

  // R3
  go_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !go_o);

  // R4
  merase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op == OP_MERASE && !(&active_mask)) |=> !go_o);

  // R11
  rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op == OP_RSVD) |=> !go_o);
endmodule

// File: tb/sim_wpg_guard.sv
`timescale 1ns/1ps
module sim_wpg_guard;
  localparam int PAGES = 64;
  localparam int GR    = PAGES / 2;
  localparam int PW    = $clog2(PAGES);
  localparam logic [GR-1:0] MASK_A = 32'hFFFF_FFF5; // groups 1 and 3 protected

  typedef struct packed {
    logic [1:0] op;
    logic [5:0] page;
    logic       go;
    logic       err;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 6'd0,  1'b1, 1'b0},  // R1 group 0 open
    '{2'b00, 6'd2,  1'b0, 1'b1},  // R1 group 1 guarded
    '{2'b01, 6'd3,  1'b0, 1'b1},  // R2 erase, group 1
    '{2'b00, 6'd4,  1'b1, 1'b0},
    '{2'b01, 6'd7,  1'b0, 1'b1},  // group 3
    '{2'b00, 6'd63, 1'b1, 1'b0},
    '{2'b01, 6'd5,  1'b1, 1'b0},
    '{2'b00, 6'd6,  1'b0, 1'b1},
    '{2'b11, 6'd0,  1'b0, 1'b0},  // R11 reserved
    '{2'b10, 6'd0,  1'b0, 1'b1}   // R4 mass erase blocked
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = '0;
  logic [PW-1:0] req_page = '0;
  logic [GR-1:0] opt_mask = '0;
  logic          opt_reload = 1'b0, opt_erase = 1'b0;
  logic          done = 1'b0, pgerr = 1'b0;
  logic          eop_ie = 1'b0, err_ie = 1'b0;
  logic [2:0]    clr = '0;
  logic          go, eop, wrp, pge, irq;
  logic [1:0]    go_op;
  logic [PW-1:0] go_page;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  wpg_guard #(.NUM_PAGES(PAGES)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_page_i(req_page),
    .opt_mask_i(opt_mask), .opt_reload_i(opt_reload), .opt_erase_i(opt_erase),
    .done_i(done), .pgerr_i(pgerr), .eop_ie_i(eop_ie), .err_ie_i(err_ie),
    .clr_i(clr), .go_o(go), .go_op_o(go_op), .go_page_o(go_page),
    .eop_o(eop), .wrp_err_o(wrp), .pg_err_o(pge), .irq_o(irq)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    clr = 3'b111; cyc(); clr = '0;
  endtask

  task automatic req(input logic [1:0] op, input logic [PW-1:0] pg);
    req_valid = 1'b1; req_op = op; req_page = pg;
    cyc();
    req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    // R10 reset state
    chk(go == 0 && eop == 0 && wrp == 0 && pge == 0 && irq == 0, "R10 reset outputs",
        {go, eop, wrp, pge, irq}, 0);
    req(2'b00, 6'd10);
    chk(go == 0 && wrp == 1, "R10 protected before reload", {go, wrp}, 1);
    clear_all();

    opt_mask = MASK_A; opt_reload = 1'b1; cyc(); opt_reload = 1'b0;

    // table walk: R1 R2 R3 R4 R11
    for (int i = 0; i < NV; i++) begin
      clear_all();
      req(VEC[i].op, VEC[i].page);
      chk(go == VEC[i].go, $sformatf("R1 R2 go vec%0d", i), go, VEC[i].go);
      chk(wrp == VEC[i].err, $sformatf("R2 R4 err vec%0d", i), wrp, VEC[i].err);
      if (VEC[i].go)
        chk(go_op == VEC[i].op && go_page == VEC[i].page, $sformatf("R3 echo vec%0d", i),
            {go_op, go_page}, {VEC[i].op, VEC[i].page});
      cyc();
      chk(go == 0, $sformatf("R3 single pulse vec%0d", i), go, 0);
    end

    // R5 mask change without reload, then reload in request cycle
    clear_all();
    opt_mask = '1;
    req(2'b00, 6'd2);
    chk(go == 0 && wrp == 1, "R5 no reload keeps mask", {go, wrp}, 1);
    clear_all();
    opt_reload = 1'b1;
    req(2'b00, 6'd2);
    opt_reload = 1'b0;
    chk(go == 0 && wrp == 1, "R5 same-cycle reload uses old mask", {go, wrp}, 1);
    clear_all();
    req(2'b00, 6'd2);
    chk(go == 1 && wrp == 0, "R5 new mask after reload", {go, wrp}, 2);
    req(2'b10, 6'd0);
    chk(go == 1 && go_op == 2'b10, "R4 mass erase with all open", {go, go_op}, 6);

    // R6 option erase
    opt_mask = '0; opt_reload = 1'b1; cyc(); opt_reload = 1'b0;
    clear_all();
    opt_erase = 1'b1; cyc(); opt_erase = 1'b0;
    req(2'b00, 6'd0);
    chk(go == 0 && wrp == 1, "R6 erase alone has no effect", {go, wrp}, 1);
    opt_reload = 1'b1; cyc(); opt_reload = 1'b0;
    clear_all();
    req(2'b10, 6'd0);
    chk(go == 1 && wrp == 0, "R6 reload after erase opens all", {go, wrp}, 2);

    // R7 end of operation
    clear_all();
    done = 1'b1; cyc(); done = 1'b0;
    chk(eop == 1 && irq == 0, "R7 eop set, irq masked", {eop, irq}, 2);
    eop_ie = 1'b1; #1;
    chk(irq == 1, "R7 eop irq enabled", irq, 1);
    clr = 3'b001; cyc(); clr = '0;
    chk(eop == 0 && irq == 0, "R9 eop cleared", {eop, irq}, 0);
    eop_ie = 1'b0;

    // R8 shared error enable
    err_ie = 1'b1;
    pgerr = 1'b1; cyc(); pgerr = 1'b0;
    chk(pge == 1 && irq == 1, "R8 pgerr irq", {pge, irq}, 3);
    err_ie = 1'b0; #1;
    chk(irq == 0, "R8 err enable off", irq, 0);
    clear_all();
    opt_mask = MASK_A; opt_reload = 1'b1; cyc(); opt_reload = 1'b0;
    err_ie = 1'b1;
    req(2'b00, 6'd6);
    chk(wrp == 1 && irq == 1 && pge == 0, "R8 wrp irq", {wrp, irq, pge}, 6);

    // R9 set beats clear, then lone clear
    clr = 3'b010;
    req(2'b01, 6'd3);
    clr = '0;
    chk(wrp == 1, "R9 set wins over clear", wrp, 1);
    cyc();
    chk(wrp == 1, "R9 sticky", wrp, 1);
    clr = 3'b010; cyc(); clr = '0;
    chk(wrp == 0 && irq == 0, "R9 lone clear", {wrp, irq}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule